// File: doc/BRIEF.md
# Windowed Frame CRC Unit

The block computes one CRC signature per video frame for each colour component (red/Cr, green/Y and blue/Cb). It taps the active pixel stream, together with the pixel's x and y position, an active-pixel qualifier and an end-of-frame strobe. Only pixels that fall inside the selected capture region are folded into the signatures. The region is one of four choices: rectangle A, rectangle B, the union of both, or the whole active area.

Software programs the two rectangles and the control word through a simple write port. It then arms the engine. The engine waits for the next frame boundary, so that no partial frame is ever reported. It then accumulates one full frame and latches the three signatures at end of frame. In one-shot mode the engine disarms itself after that latch. In free-running mode it keeps latching every frame. The engine refuses to arm while the raster is stopped, and any change to a rectangle disarms it, so a result never mixes two window settings.

Top module: `frame_crc_unit`

## Requirements
- R1: Each component signature is CRC-16 with polynomial 0x1021 and seed 0xFFFF. Each component value is shifted in MSB first, and a new frame starts from the seed. With the full active area selected and a frame whose red values are the bytes "123456789", the red result is 0x29B1.
- R2: Rectangle bounds are inclusive (start <= pos <= end). The select field picks the region as follows: 0 = rectangle A, 1 = rectangle B, 2 = union of A and B (a pixel counts once), 3 = every active pixel. A rectangle whose start is above its end captures nothing, and its result stays 0xFFFF.
- R3: Pixels with active_i low do not change the signatures, and neither does the pixel on an eof_i cycle. After arming, the rest of the current frame is discarded. Capture begins after the first end of frame.
- R4: On the end-of-frame strobe of a capturing frame, the three signatures are latched and the valid flag is set. Both are readable in the next cycle. The latched results do not change at any other time.
- R5: In one-shot mode (control bit1 = 0), enable clears after one latch. Valid stays set, and the results stay frozen through later frames.
- R6: In free-running mode (control bit1 = 1), enable stays set and the results are re-latched at every end of frame.
- R7: A control write with enable set while raster_en_i is low leaves enable at 0.
- R8: A write to any rectangle register clears enable and valid. So does a control write. A control write with enable set re-arms the engine.
- R9: raster_en_i low clears enable and valid.
- R10: Register map for the 3-bit addresses. Address 0 is control/status: bit0 enable, bit1 free-run, bits[3:2] select, bit4 valid. Addresses 1 to 4 hold the rectangle bounds A-x, A-y, B-x, B-y, each with start in [15:0] and end in [31:16]. Address 5 holds green in [31:16] and red in [15:0]. Address 6 holds blue in [15:0]. Addresses 5 and 6 read 0 while valid is 0.
- R11: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raster_en_i | input | 1 | Raster running |
| active_i | input | 1 | Current pixel is in the active area |
| eof_i | input | 1 | End-of-frame strobe, on a non-pixel cycle |
| x_i | input | CRD_W | Horizontal pixel position |
| y_i | input | CRD_W | Vertical pixel position |
| red_i | input | CW | Red / Cr component |
| green_i | input | CW | Green / Y component |
| blue_i | input | CW | Blue / Cb component |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register write address |
| cfg_wdata_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |

## Verification
The bench uses the defaults CW = 8 and CRD_W = 12. With 8-bit components, a frame of ASCII digits reproduces the published CRC-16 check value 0x29B1. The 12-bit coordinates let a small 8x4 raster place rectangles on every edge, on a single corner pixel, and in an empty inverted range. Every frame also carries blanking cycles with non-zero pixel data at in-window coordinates. A sync frame with different content precedes each measured frame, so leakage from blanking or from a partial frame changes the expected signature.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
  localparam int unsigned CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam int unsigned N_COMP   = 3;
  localparam int unsigned N_WIN    = 2;

  typedef enum logic [1:0] {
    SEL_WIN_A  = 2'd0,
    SEL_WIN_B  = 2'd1,
    SEL_UNION  = 2'd2,
    SEL_ACTIVE = 2'd3
  } crc_sel_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_AX   = 3'd1;
  localparam logic [2:0] ADDR_BY   = 3'd4;
  localparam logic [2:0] ADDR_RG   = 3'd5;
  localparam logic [2:0] ADDR_B    = 3'd6;
endpackage

// File: rtl/frame_crc_window.sv
module frame_crc_window #(
  parameter int unsigned CRD_W = 12
) (
  input  logic [CRD_W-1:0] x_i,
  input  logic [CRD_W-1:0] y_i,
  input  logic [CRD_W-1:0] x_lo_i,
  input  logic [CRD_W-1:0] x_hi_i,
  input  logic [CRD_W-1:0] y_lo_i,
  input  logic [CRD_W-1:0] y_hi_i,
  output logic             hit_o
);
  logic x_in, y_in;
  assign x_in  = (x_i >= x_lo_i) && (x_i <= x_hi_i);
  assign y_in  = (y_i >= y_lo_i) && (y_i <= y_hi_i);
  assign hit_o = x_in && y_in;
endmodule

// File: rtl/frame_crc_lane.sv
module frame_crc_lane
  import frame_crc_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reseed_i,
  input  logic             upd_i,
  input  logic [CW-1:0]    data_i,
  output logic [CRC_W-1:0] acc_o
);
  logic [CRC_W-1:0] acc_q;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [CW-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = CW - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= CRC_SEED;
    else if (reseed_i) acc_q <= CRC_SEED;
    else if (upd_i)    acc_q <= crc_step(acc_q, data_i);
  end

  assign acc_o = acc_q;

  a_r1_reseed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseed_i |=> (acc_q == CRC_SEED));
  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reseed_i && !upd_i) |=> $stable(acc_q));
endmodule

// File: rtl/frame_crc_ctrl.sv
module frame_crc_ctrl
  import frame_crc_pkg::*;
#(
  parameter int unsigned CRD_W = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        raster_en_i,
  input  logic                        eof_i,
  input  logic                        cfg_we_i,
  input  logic [2:0]                  cfg_addr_i,
  input  logic [31:0]                 cfg_wdata_i,
  output logic                        en_o,
  output logic                        cont_o,
  output crc_sel_e                    sel_o,
  output logic                        valid_o,
  output logic                        collect_o,
  output logic                        latch_o,
  output logic [3:0][CRD_W-1:0]       lo_o,
  output logic [3:0][CRD_W-1:0]       hi_o
);
  logic     en_q, cont_q, sync_q, valid_q;
  crc_sel_e sel_q;
  logic     ctrl_wr, win_wr;
  logic     unused_wdata;

  assign ctrl_wr = cfg_we_i && (cfg_addr_i == ADDR_CTRL);
  assign win_wr  = cfg_we_i && (cfg_addr_i >= ADDR_AX) && (cfg_addr_i <= ADDR_BY);
  assign unused_wdata = ^cfg_wdata_i;

  for (genvar k = 0; k < 4; k++) begin : g_bound
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_o[k] <= '0;
        hi_o[k] <= '0;
      end else if (cfg_we_i && (cfg_addr_i == 3'(k + 1))) begin
        lo_o[k] <= cfg_wdata_i[CRD_W-1:0];
        hi_o[k] <= cfg_wdata_i[16 +: CRD_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q <= 1'b0;
      sel_q  <= SEL_WIN_A;
    end else if (ctrl_wr) begin
      cont_q <= cfg_wdata_i[1];
      sel_q  <= crc_sel_e'(cfg_wdata_i[3:2]);
    end
  end

  // arm / sync / latch sequencing; disarm sources take priority over frame events
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sync_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (!raster_en_i) begin
      en_q    <= 1'b0;
      sync_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q    <= cfg_wdata_i[0];
      sync_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (win_wr) begin
      en_q    <= 1'b0;
      sync_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (en_q && eof_i) begin
      if (!sync_q) begin
        sync_q <= 1'b1;
      end else begin
        valid_q <= 1'b1;
        if (!cont_q) begin
          en_q   <= 1'b0;
          sync_q <= 1'b0;
        end
      end
    end
  end

  assign collect_o = en_q && sync_q && raster_en_i;
  assign latch_o   = collect_o && eof_i && !ctrl_wr && !win_wr;
  assign en_o      = en_q;
  assign cont_o    = cont_q;
  assign sel_o     = sel_q;
  assign valid_o   = valid_q;

  a_r7_arm_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !raster_en_i) |=> !en_q);
  a_r9_raster_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !raster_en_i |=> (!en_q && !valid_q));
  a_r8_window_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr |=> (!en_q && !valid_q));
  a_r5_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o && !cont_q) |=> (!en_q && valid_q));
  a_r6_cont_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_o && cont_q) |=> (en_q && valid_q));
  a_r3_no_latch_after_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !latch_o);
endmodule

// File: rtl/frame_crc_unit.sv
module frame_crc_unit
  import frame_crc_pkg::*;
#(
  parameter int unsigned CW    = 8,
  parameter int unsigned CRD_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raster_en_i,
  input  logic             active_i,
  input  logic             eof_i,
  input  logic [CRD_W-1:0] x_i,
  input  logic [CRD_W-1:0] y_i,
  input  logic [CW-1:0]    red_i,
  input  logic [CW-1:0]    green_i,
  input  logic [CW-1:0]    blue_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [2:0]       rd_addr_i,
  output logic [31:0]      rd_data_o
);
  logic                           en, cont, valid, collect, latch;
  crc_sel_e                       sel;
  logic [3:0][CRD_W-1:0]          lo, hi;
  logic [N_WIN-1:0]               hit;
  logic                           in_region, upd;
  logic [N_COMP-1:0][CW-1:0]      pix;
  logic [N_COMP-1:0][CRC_W-1:0]   acc;
  logic [N_COMP-1:0][CRC_W-1:0]   res_q;

  frame_crc_ctrl #(.CRD_W(CRD_W)) u_ctrl (
    .clk_i, .rst_ni, .raster_en_i, .eof_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .en_o(en), .cont_o(cont), .sel_o(sel), .valid_o(valid),
    .collect_o(collect), .latch_o(latch), .lo_o(lo), .hi_o(hi)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    frame_crc_window #(.CRD_W(CRD_W)) u_win (
      .x_i, .y_i,
      .x_lo_i(lo[2*w]), .x_hi_i(hi[2*w]),
      .y_lo_i(lo[2*w+1]), .y_hi_i(hi[2*w+1]),
      .hit_o(hit[w])
    );
  end

  always_comb begin
    case (sel)
      SEL_WIN_A: in_region = hit[0];
      SEL_WIN_B: in_region = hit[1];
      SEL_UNION: in_region = |hit;
      default:   in_region = 1'b1;
    endcase
  end

  assign upd = collect && active_i && !eof_i && in_region;
  assign pix = {blue_i, green_i, red_i};

  for (genvar c = 0; c < N_COMP; c++) begin : g_lane
    frame_crc_lane #(.CW(CW)) u_lane (
      .clk_i, .rst_ni, .reseed_i(eof_i), .upd_i(upd),
      .data_i(pix[c]), .acc_o(acc[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_q <= '0;
    else if (latch) res_q <= acc;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_CTRL: rd_data_o = {27'd0, valid, sel, cont, en};
      ADDR_RG:   if (valid) rd_data_o = {res_q[1], res_q[0]};
      ADDR_B:    if (valid) rd_data_o = {16'd0, res_q[2]};
      default: begin
        for (int k = 0; k < 4; k++) begin
          if (rd_addr_i == 3'(k + 1)) begin
            rd_data_o[CRD_W-1:0]  = lo[k];
            rd_data_o[16 +: CRD_W] = hi[k];
          end
        end
      end
    endcase
  end

  a_r4_results_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch |=> $stable(res_q));
  a_r4_latch_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> valid);
  a_r3_no_update_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !upd);
endmodule

// File: tb/tb_frame_crc_unit.sv
module tb_frame_crc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int CRD_W = 12;
  localparam int FW = 8;
  localparam int FH = 4;

  typedef struct packed {
    logic [1:0]  sel;
    logic [11:0] ax0, ax1, ay0, ay1, bx0, bx1, by0, by1;
    logic [7:0]  salt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'd1, 12'd4, 12'd0, 12'd2, 12'd5, 12'd7, 12'd2, 12'd3, 8'd1},
    '{2'd1, 12'd1, 12'd4, 12'd0, 12'd2, 12'd5, 12'd7, 12'd2, 12'd3, 8'd2},
    '{2'd2, 12'd0, 12'd3, 12'd0, 12'd1, 12'd2, 12'd6, 12'd1, 12'd3, 8'd3},
    '{2'd3, 12'd2, 12'd2, 12'd2, 12'd2, 12'd0, 12'd0, 12'd0, 12'd0, 8'd4},
    '{2'd0, 12'd7, 12'd7, 12'd3, 12'd3, 12'd0, 12'd7, 12'd0, 12'd3, 8'd5},
    '{2'd0, 12'd5, 12'd4, 12'd0, 12'd3, 12'd0, 12'd7, 12'd0, 12'd3, 8'd6}
  };

  logic clk = 0, rst_n = 0, raster_en = 0, active = 0, eof = 0;
  logic [CRD_W-1:0] x = 0, y = 0;
  logic [CW-1:0] red = 0, green = 0, blue = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0, rd_addr = 0;
  logic [31:0] cfg_wdata = 0, rd_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_crc_unit #(.CW(CW), .CRD_W(CRD_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .raster_en_i(raster_en), .active_i(active),
    .eof_i(eof), .x_i(x), .y_i(y), .red_i(red), .green_i(green), .blue_i(blue),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [7:0] pixv(int px, int py, int salt, int c);
    return 8'((px * 37 + py * 91 + salt * 13 + c * 59) ^ (py << 3));
  endfunction

  function automatic logic [15:0] step8(logic [15:0] s, logic [7:0] d);
    s = s ^ {d, 8'h00};
    repeat (8) s = s[15] ? ((s << 1) ^ 16'h1021) : (s << 1);
    return s;
  endfunction

  function automatic bit inside_sel(vec_t v, int px, int py);
    bit a, b;
    a = px >= v.ax0 && px <= v.ax1 && py >= v.ay0 && py <= v.ay1;
    b = px >= v.bx0 && px <= v.bx1 && py >= v.by0 && py <= v.by1;
    case (v.sel)
      2'd0: return a;
      2'd1: return b;
      2'd2: return a || b;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] model(vec_t v, int salt, int c);
    logic [15:0] s = 16'hFFFF;
    for (int py = 0; py < FH; py++)
      for (int px = 0; px < FW; px++)
        if (inside_sel(v, px, py)) s = step8(s, pixv(px, py, salt, c));
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic run_frame(int salt);
    for (int py = 0; py < FH; py++) begin
      for (int px = 0; px < FW; px++) begin
        @(negedge clk); active = 1; x = CRD_W'(px); y = CRD_W'(py);
        red = pixv(px, py, salt, 0); green = pixv(px, py, salt, 1); blue = pixv(px, py, salt, 2);
      end
      // blanking with in-window coordinates and live data
      @(negedge clk); active = 0; x = 0; y = CRD_W'(py); red = 8'hA5; green = 8'h5A; blue = 8'h3C;
    end
    @(negedge clk); active = 0; eof = 1;
    @(negedge clk); eof = 0;
  endtask

  task automatic run_ascii;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); active = 1; x = CRD_W'(i); y = 0;
      red = 8'(8'h31 + i); green = 0; blue = 0;
    end
    @(negedge clk); active = 0; eof = 1; red = 8'h77;
    @(negedge clk); eof = 0;
  endtask

  task automatic load_win(vec_t v);
    wr(3'd1, {4'd0, v.ax1, 4'd0, v.ax0});
    wr(3'd2, {4'd0, v.ay1, 4'd0, v.ay0});
    wr(3'd3, {4'd0, v.bx1, 4'd0, v.bx0});
    wr(3'd4, {4'd0, v.by1, 4'd0, v.by0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    vec_t vc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state, R10 results zero while invalid
    rd(3'd0, d); chk("R11 ctrl", d, 0);
    rd(3'd1, d); chk("R11 win", d, 0);
    rd(3'd5, d); chk("R10 rg invalid", d, 0);

    // R7 arm refused while raster stopped
    wr(3'd0, 32'h1);
    rd(3'd0, d); chk("R7 refused", d, 0);
    raster_en = 1;

    // table: one-shot capture per vector (R1 R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      vc = VECS[i];
      load_win(vc);
      wr(3'd0, {28'd0, vc.sel, 2'b01});
      run_frame(int'(vc.salt) + 100);
      run_frame(int'(vc.salt));
      rd(3'd0, d); chk("R5 one-shot status", d, {27'd0, 1'b1, vc.sel, 2'b00});
      rd(3'd5, d); chk("R2 rg", d, {model(vc, vc.salt, 1), model(vc, vc.salt, 0)});
      rd(3'd6, d); chk("R2 blue", d, {16'd0, model(vc, vc.salt, 2)});
    end

    // R1 check value, then R5 frozen after one-shot
    wr(3'd0, 32'h0000_000D);
    run_frame(9);
    run_ascii;
    rd(3'd5, d); chk("R1 check value", {16'd0, d[15:0]}, 32'h29B1);
    run_frame(11);
    rd(3'd5, d); chk("R5 frozen", {16'd0, d[15:0]}, 32'h29B1);

    // R6 free-running
    vc = VECS[3];
    wr(3'd0, 32'h0000_000F);
    run_frame(40);
    run_frame(7);
    rd(3'd0, d); chk("R6 status", d, 32'h1F);
    rd(3'd5, d); chk("R6 frame1", d, {model(vc, 7, 1), model(vc, 7, 0)});
    run_frame(8);
    rd(3'd5, d); chk("R6 frame2", d, {model(vc, 8, 1), model(vc, 8, 0)});
    rd(3'd6, d); chk("R4 blue frame2", d, {16'd0, model(vc, 8, 2)});

    // R8 window write disarms
    wr(3'd1, 32'h0007_0000);
    rd(3'd0, d); chk("R8 disarm", d, 32'h0E);
    rd(3'd5, d); chk("R10 rg after disarm", d, 0);

    // R9 raster stop
    wr(3'd0, 32'h0000_000F);
    run_frame(20);
    run_frame(21);
    rd(3'd0, d); chk("R9 before stop", d, 32'h1F);
    @(negedge clk); raster_en = 0;
    @(negedge clk); raster_en = 1;
    rd(3'd0, d); chk("R9 after stop", d, 32'h0E);
    rd(3'd6, d); chk("R10 blue invalid", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule